// File: doc/BRIEF.md
# Sector Write Sequencer with FM Encoding

This block drives the write path for one sector of a hard-sectored diskette. A start command carries the sector number to write. The block first asks a DMA channel for the first data word, so that the word is waiting before the sector arrives. It then waits for the next hard sector mark. It hunts the read-side bit stream for the address sync bit and discards that bit. It then shifts in the 16-bit address preamble and compares the sector field with the commanded sector. The write is made only if the two agree.

On a match, the block waits a fixed gap with the write gate off. It then opens the write gate and sends a run of zero cells as the leader, followed by a single one cell as the sync. After that come the data words and a 16-bit CRC computed over those words. Every bit cell carries a clock pulse in its first half and the data value in its second half, so that clock and data travel on one wire.

The channel supplies each data word through a request/acknowledge handshake. A word that has not arrived by the time the shifter needs it ends the command with a data-late error. A write-protected medium is refused at start, and the write gate is never opened.

Top module: `sector_writer`

## Requirements
- R1: A start accepted while idle with `write_protect` high sets `err_protect` and pulses `done` on the following cycle. `word_req` and `write_gate` stay low and the block stays idle.
- R2: A start accepted while idle with `write_protect` low raises `word_req` (the prefetch) on the following cycle, before any sector mark, and the block becomes busy.
- R3: Read bits before the sector mark are ignored. After the mark, zero bits are skipped, the first one bit is taken as the sync and discarded, and the next 16 valid bits form the preamble, most significant bit first.
- R4: The sector number sits in preamble bits [SEC_W-1:0] and is compared with the target latched at start; all other preamble bits are ignored. On a mismatch the block sets `err_mismatch`, pulses `done` and returns to idle without opening the write gate.
- R5: On a match, `write_gate` rises exactly 1 + GAP_CELLS*2*HALF_CLKS clock edges after the edge that takes the last preamble bit.
- R6: While the gate is open, the stream starts with LEADER_CELLS cells of bit 0, followed by exactly one cell of bit 1 (the sync).
- R7: Each bit cell lasts 2*HALF_CLKS cycles. `fm_out` is 1 for the first HALF_CLKS cycles and equals the cell's bit for the second HALF_CLKS cycles.
- R8: After the sync, exactly N_WORDS (256 by default) words are sent, each most significant bit first, in the order the channel supplied them.
- R9: The data is followed by a 16-bit CRC sent most significant bit first. The CRC uses the polynomial x^16+x^12+x^5+1, starts from all ones, and covers the data bits in the order they are sent. The gate then drops and `done` pulses, with no error set.
- R10: `word_req` stays high until `word_ack`. The prefetch is the first request. A further request follows each edge at which a word enters the shifter, while fewer than N_WORDS requests have been made. So exactly N_WORDS words are requested, and `word_req` is low whenever the block is idle.
- R11: An acknowledge in the same cycle as the edge that loads the shifter is accepted. If no word is held or arriving at that edge, the block sets `err_late`, drops the write gate at once and pulses `done`.
- R12: A start while busy is ignored: the error flags and the sequence running at that time are not disturbed.
- R13: `done` is a single-cycle pulse. All error flags clear on the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start a sector write (accepted only when idle) |
| target_sector | input | SEC_W | Sector number to write, latched at start |
| write_protect | input | 1 | Medium is write protected |
| sector_mark | input | 1 | One-cycle pulse at a hard sector mark |
| rd_valid | input | 1 | Read-side bit strobe |
| rd_bit | input | 1 | Read-side separated data bit |
| word_req | output | 1 | Request for the next data word |
| word_ack | input | 1 | Channel presents a word this cycle |
| word_data | input | 16 | Data word from the channel |
| write_gate | output | 1 | Write current enable |
| fm_out | output | 1 | FM-encoded serial write stream |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| err_protect | output | 1 | Command refused because of write protect |
| err_mismatch | output | 1 | Sector address did not match the target |
| err_late | output | 1 | Channel word arrived too late |

## Verification
The event that can fall in the same cycle is the channel's acknowledge and the shifter load at a word boundary: the arriving word must be passed straight through, and the request for the following word must win over the clear caused by the acknowledge. The bench provokes this by answering each request after a chosen number of cycles. A delay of exactly one word time (16 cells) lands the acknowledge on the load edge, and that run must complete with a correct stream and CRC. A delay one cycle longer must end in `err_late` with the gate dropped.

// File: rtl/sector_writer_pkg.sv
// Shared definitions for the sector write sequencer.
// Assumes 16-bit channel words and a 16-bit address preamble.
package sector_writer_pkg;

    localparam int WORD_W   = 16;
    localparam int PRE_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    // Sequencer phases, in the order a successful command visits them.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_MARK,
        ST_RECV,
        ST_GAP,
        ST_LEADER,
        ST_SYNC,
        ST_DATA,
        ST_CRC
    } wr_state_t;

endpackage

// File: rtl/fm_cell_timer.sv
// Bit-cell timer: splits each cell into a clock half (phase 0) and a
// data half (phase 1), each HALF_CLKS cycles long.
// Assumes: clear holds the timer at the start of a cell.
module fm_cell_timer #(
    parameter int HALF_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic phase,
    output logic cell_end
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF_CLKS - 1);

    logic [CW-1:0] cnt;
    logic          half_end;

    assign half_end = (cnt == HALF_LAST);
    assign cell_end = half_end & phase;

    // Count cycles within a half cell and toggle the half at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (clear) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (half_end) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/preamble_receiver.sv
// Preamble receiver: while enabled, skips zero bits and takes the first
// one bit as the sync (discarded), then collects PRE_W bits MSB first.
// Only the low OUT_W bits are kept; word_valid pulses one cycle after
// the edge that takes the last bit.
// Assumes OUT_W >= 2 and OUT_W <= PRE_W.
module preamble_receiver #(
    parameter int PRE_W = 16,
    parameter int OUT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [OUT_W-1:0] word,
    output logic             word_valid
);
    localparam int CW = $clog2(PRE_W);
    localparam logic [CW-1:0] CNT_LAST = CW'(PRE_W - 1);

    logic [CW-1:0] cnt;
    logic          locked;

    // Sync hunt, then shift and count the preamble bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            locked     <= 1'b0;
            word       <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (!enable) begin
                cnt    <= '0;
                locked <= 1'b0;
            end else if (bit_valid) begin
                if (!locked) begin
                    locked <= bit_in;
                end else begin
                    word <= {word[OUT_W-2:0], bit_in};
                    cnt  <= cnt + CW'(1);
                    if (cnt == CNT_LAST) begin
                        word_valid <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/crc16_serial.sv
// Serial CRC-16 generator: init presets, update folds in one data bit,
// shift moves the remainder out MSB first with zero fill.
// Assumes the three controls are never asserted together.
module crc16_serial #(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021,
    parameter logic [W-1:0] INIT = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         update,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] crc
);
    logic fb;

    assign fb = crc[W-1] ^ bit_in;

    // Remainder register: preset, divide by one bit, or shift out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= INIT;
        end else if (init) begin
            crc <= INIT;
        end else if (update) begin
            crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end else if (shift) begin
            crc <= {crc[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/word_prefetch.sv
// One-word prefetch buffer on the channel handshake. req stays high
// until ack. take pulls a word: the held one, or the one acknowledged
// in that same cycle (bypass), and issues the next request while fewer
// than N_WORDS have been requested. flush drops the request and the word.
// Assumes the channel acknowledges only while req is high.
module word_prefetch #(
    parameter int W       = 16,
    parameter int N_WORDS = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         prefetch,
    input  logic         take,
    input  logic         flush,
    input  logic         ack,
    input  logic [W-1:0] ack_data,
    output logic         req,
    output logic         avail,
    output logic [W-1:0] out_data
);
    localparam int IW = $clog2(N_WORDS + 1);
    localparam logic [IW-1:0] ISSUE_MAX = IW'(N_WORDS);

    logic [IW-1:0] issued;
    logic          full;
    logic [W-1:0]  held;
    logic          got;

    assign got      = ack & req;
    assign avail    = full | got;
    assign out_data = full ? held : ack_data;

    // Request generation and request count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req    <= 1'b0;
            issued <= '0;
        end else if (flush) begin
            req    <= 1'b0;
            issued <= '0;
        end else if (prefetch) begin
            req    <= 1'b1;
            issued <= IW'(1);
        end else if (take && avail && issued != ISSUE_MAX) begin
            req    <= 1'b1;
            issued <= issued + IW'(1);
        end else if (got) begin
            req    <= 1'b0;
        end
    end

    // Holding register for a word that arrived ahead of its load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            held <= '0;
        end else if (flush || (take && avail)) begin
            full <= 1'b0;
        end else if (got) begin
            full <= 1'b1;
            held <= ack_data;
        end
    end

endmodule

// File: rtl/sector_writer.sv
// Sector write sequencer: prefetches the first word, waits for a hard
// sector mark, checks the sector address in the preamble, then after a
// fixed gap sends leader, sync, N_WORDS data words and a CRC as an
// FM stream under the write gate.
// Assumes sector_mark is a single-cycle pulse and rd_valid strobes
// separated read bits.
module sector_writer #(
    parameter int SEC_W        = 3,
    parameter int N_WORDS      = 256,
    parameter int HALF_CLKS    = 4,
    parameter int GAP_CELLS    = 38,
    parameter int LEADER_CELLS = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEC_W-1:0] target_sector,
    input  logic             write_protect,
    input  logic             sector_mark,
    input  logic             rd_valid,
    input  logic             rd_bit,
    output logic             word_req,
    input  logic             word_ack,
    input  logic [15:0]      word_data,
    output logic             write_gate,
    output logic             fm_out,
    output logic             busy,
    output logic             done,
    output logic             err_protect,
    output logic             err_mismatch,
    output logic             err_late
);
    import sector_writer_pkg::*;

    localparam int MAXC = (GAP_CELLS > LEADER_CELLS) ? GAP_CELLS : LEADER_CELLS;
    localparam int CCW  = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CCW-1:0] GAP_LAST  = CCW'(GAP_CELLS - 1);
    localparam logic [CCW-1:0] LEAD_LAST = CCW'(LEADER_CELLS - 1);
    localparam int WCW  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam logic [WCW-1:0] WORD_LAST = WCW'(N_WORDS - 1);
    localparam int BCW  = $clog2(WORD_W);
    localparam logic [BCW-1:0] BIT_LAST = BCW'(WORD_W - 1);

    wr_state_t         state;
    logic [CCW-1:0]    cell_cnt;
    logic [BCW-1:0]    bit_cnt;
    logic [WCW-1:0]    word_cnt;
    logic [WORD_W-1:0] shreg;
    logic [SEC_W-1:0]  target_q;

    logic              phase, cell_end, timer_clear;
    logic [SEC_W-1:0]  pre_sector;
    logic              pre_valid, pre_en, sector_hit;
    logic              buf_avail;
    logic [WORD_W-1:0] buf_data;
    logic [15:0]       crc;
    logic              prefetch, take, flush;
    logic              crc_init, crc_upd, crc_shift;
    logic              cur_bit, last_bit, last_word;

    assign busy        = (state != ST_IDLE);
    assign pre_en      = (state == ST_RECV);
    assign sector_hit  = (pre_sector == target_q);
    assign last_bit    = (bit_cnt == BIT_LAST);
    assign last_word   = (word_cnt == WORD_LAST);
    assign write_gate  = (state == ST_LEADER) || (state == ST_SYNC) ||
                         (state == ST_DATA)   || (state == ST_CRC);
    assign timer_clear = !(write_gate || state == ST_GAP);
    assign fm_out      = write_gate & (~phase | cur_bit);

    fm_cell_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (timer_clear),
        .phase    (phase),
        .cell_end (cell_end)
    );

    preamble_receiver #(.PRE_W(PRE_W), .OUT_W(SEC_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (pre_en),
        .bit_valid  (rd_valid),
        .bit_in     (rd_bit),
        .word       (pre_sector),
        .word_valid (pre_valid)
    );

    word_prefetch #(.W(WORD_W), .N_WORDS(N_WORDS)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .prefetch (prefetch),
        .take     (take),
        .flush    (flush),
        .ack      (word_ack),
        .ack_data (word_data),
        .req      (word_req),
        .avail    (buf_avail),
        .out_data (buf_data)
    );

    crc16_serial #(.W(16), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (crc_init),
        .update (crc_upd),
        .shift  (crc_shift),
        .bit_in (shreg[WORD_W-1]),
        .crc    (crc)
    );

    // Select the bit carried by the current cell.
    always_comb begin
        case (state)
            ST_SYNC: cur_bit = 1'b1;
            ST_DATA: cur_bit = shreg[WORD_W-1];
            ST_CRC:  cur_bit = crc[15];
            default: cur_bit = 1'b0;
        endcase
    end

    // Strobes to the buffer and CRC, decoded from phase and cell timing.
    always_comb begin
        prefetch  = 1'b0;
        take      = 1'b0;
        flush     = 1'b0;
        crc_init  = 1'b0;
        crc_upd   = 1'b0;
        crc_shift = 1'b0;
        case (state)
            ST_IDLE: prefetch = start & ~write_protect;
            ST_RECV: flush = pre_valid & ~sector_hit;
            ST_SYNC: begin
                if (cell_end) begin
                    crc_init = 1'b1;
                    take     = buf_avail;
                    flush    = ~buf_avail;
                end
            end
            ST_DATA: begin
                if (cell_end) begin
                    crc_upd = 1'b1;
                    if (last_bit && !last_word) begin
                        take  = buf_avail;
                        flush = ~buf_avail;
                    end
                end
            end
            ST_CRC: begin
                if (cell_end) begin
                    crc_shift = 1'b1;
                    flush     = last_bit;
                end
            end
            default: ;
        endcase
    end

    // Phase sequencing, counters, data shifter and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cell_cnt     <= '0;
            bit_cnt      <= '0;
            word_cnt     <= '0;
            shreg        <= '0;
            target_q     <= '0;
            done         <= 1'b0;
            err_protect  <= 1'b0;
            err_mismatch <= 1'b0;
            err_late     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        err_protect  <= write_protect;
                        err_mismatch <= 1'b0;
                        err_late     <= 1'b0;
                        target_q     <= target_sector;
                        if (write_protect) begin
                            done  <= 1'b1;
                        end else begin
                            state <= ST_WAIT_MARK;
                        end
                    end
                end
                ST_WAIT_MARK: begin
                    if (sector_mark) begin
                        state <= ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (pre_valid) begin
                        if (sector_hit) begin
                            state    <= ST_GAP;
                            cell_cnt <= '0;
                        end else begin
                            err_mismatch <= 1'b1;
                            done         <= 1'b1;
                            state        <= ST_IDLE;
                        end
                    end
                end
                ST_GAP: begin
                    if (cell_end) begin
                        if (cell_cnt == GAP_LAST) begin
                            state    <= ST_LEADER;
                            cell_cnt <= '0;
                        end else begin
                            cell_cnt <= cell_cnt + CCW'(1);
                        end
                    end
                end
                ST_LEADER: begin
                    if (cell_end) begin
                        if (cell_cnt == LEAD_LAST) begin
                            state    <= ST_SYNC;
                            cell_cnt <= '0;
                        end else begin
                            cell_cnt <= cell_cnt + CCW'(1);
                        end
                    end
                end
                ST_SYNC: begin
                    if (cell_end) begin
                        if (buf_avail) begin
                            shreg    <= buf_data;
                            bit_cnt  <= '0;
                            word_cnt <= '0;
                            state    <= ST_DATA;
                        end else begin
                            err_late <= 1'b1;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    if (cell_end) begin
                        bit_cnt <= bit_cnt + BCW'(1);
                        shreg   <= {shreg[WORD_W-2:0], 1'b0};
                        if (last_bit) begin
                            if (last_word) begin
                                state <= ST_CRC;
                            end else if (buf_avail) begin
                                shreg    <= buf_data;
                                word_cnt <= word_cnt + WCW'(1);
                            end else begin
                                err_late <= 1'b1;
                                done     <= 1'b1;
                                state    <= ST_IDLE;
                            end
                        end
                    end
                end
                ST_CRC: begin
                    if (cell_end) begin
                        bit_cnt <= bit_cnt + BCW'(1);
                        if (last_bit) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sector_writer_chk.sv
// Property checker for the sector write sequencer, bound to every
// instance of the top module. Observes ports only.
module sector_writer_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic write_protect,
    input logic busy,
    input logic done,
    input logic word_req,
    input logic write_gate,
    input logic fm_out,
    input logic err_protect,
    input logic err_mismatch,
    input logic err_late
);

    assert_protect_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && write_protect |=> err_protect && done && !busy && !word_req);

    assert_prefetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !write_protect |=> word_req && busy);

    assert_mismatch_no_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_mismatch |-> !write_gate);

    assert_gate_opens_on_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(write_gate) |-> fm_out);

    assert_idle_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !word_req);

    assert_late_drops_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_late) |-> !write_gate && done);

    assert_busy_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start && busy |=> $stable(err_protect));

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind sector_writer sector_writer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .write_protect (write_protect),
    .busy          (busy),
    .done          (done),
    .word_req      (word_req),
    .write_gate    (write_gate),
    .fm_out        (fm_out),
    .err_protect   (err_protect),
    .err_mismatch  (err_mismatch),
    .err_late      (err_late)
);

// File: tb/sim_sector_writer.sv
// Bench for the sector write sequencer: small configuration, sweeps of
// target/sector pairs, and handshake delays around the load edge.
module sim_sector_writer;
    localparam int SW   = 3;
    localparam int NW   = 32;
    localparam int H    = 2;
    localparam int GAP  = 3;
    localparam int LEAD = 4;
    localparam int CELL = 2 * H;
    localparam int NCELL = LEAD + 1 + NW * 16 + 16;
    localparam int MAXCAP = NCELL * CELL + 64;

    logic clk = 0, rst_n = 0;
    logic start = 0, write_protect = 0, sector_mark = 0, rd_valid = 0, rd_bit = 0;
    logic [SW-1:0] target_sector = '0;
    logic word_req, word_ack = 0;
    logic [15:0] word_data = '0;
    logic write_gate, fm_out, busy, done, err_protect, err_mismatch, err_late;

    int tests = 0, fails = 0, cyc = 0;
    int ack_delay = 1, first_delay = 3, acks = 0, data_mode = 0;
    bit lv [MAXCAP];
    int cap_n = 0;
    bit gate_seen = 0, done_seen = 0, req_seen = 0;

    always #5 clk = ~clk;

    sector_writer #(.SEC_W(SW), .N_WORDS(NW), .HALF_CLKS(H),
                    .GAP_CELLS(GAP), .LEADER_CELLS(LEAD)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .target_sector(target_sector),
        .write_protect(write_protect), .sector_mark(sector_mark),
        .rd_valid(rd_valid), .rd_bit(rd_bit), .word_req(word_req),
        .word_ack(word_ack), .word_data(word_data), .write_gate(write_gate),
        .fm_out(fm_out), .busy(busy), .done(done), .err_protect(err_protect),
        .err_mismatch(err_mismatch), .err_late(err_late));

    function automatic logic [15:0] wval(int k);
        case (data_mode)
            0: wval = 16'(k * 40503) ^ 16'h5A3C;
            1: wval = (k % 2 == 0) ? 16'hFFFF : 16'h0000;
            default: wval = 16'(k << 9) ^ 16'(k * 7 + 1);
        endcase
    endfunction

    function automatic logic [15:0] exp_crc();
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < NW; k++)
            for (int b = 15; b >= 0; b--) begin
                logic fb = c[15] ^ wval(k)[b];
                c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
        return c;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 180000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 180000);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    // Monitor: capture the stream under the gate and note events.
    initial begin
        forever begin
            @(negedge clk);
            if (write_gate) begin
                gate_seen = 1;
                if (cap_n < MAXCAP) begin lv[cap_n] = fm_out; cap_n++; end
            end
            if (done) done_seen = 1;
            if (word_req) req_seen = 1;
        end
    end

    // Channel model: acknowledge each request after a chosen delay.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (word_ack) begin word_ack = 0; cnt = 0; end
            if (!word_req) cnt = 0;
            else begin
                cnt++;
                if (cnt == ((acks == 0) ? first_delay : ack_delay)) begin
                    word_ack = 1;
                    word_data = wval(acks);
                    acks++;
                end
            end
        end
    end

    task automatic clear_obs();
        cap_n = 0; gate_seen = 0; done_seen = 0; req_seen = 0; acks = 0;
    endtask

    task automatic do_start(int tgt, bit wp);
        @(negedge clk);
        start = 1; target_sector = SW'(tgt); write_protect = wp;
        @(negedge clk);
        start = 0; write_protect = 0;
    endtask

    task automatic wait_done(int limit);
        for (int i = 0; i < limit && !done_seen; i++) @(negedge clk);
    endtask

    // Mark, optional noise before it, leading zeros, sync, 16 bits MSB first.
    // Returns the edge count from the last bit's edge to the gate rising.
    task automatic send_preamble(logic [15:0] addr, int zeros, output int gap_n);
        @(negedge clk);
        rd_valid = 1; rd_bit = 1;
        @(negedge clk);
        rd_valid = 0;
        sector_mark = 1;
        @(negedge clk);
        sector_mark = 0;
        for (int i = 0; i < zeros; i++) begin rd_valid = 1; rd_bit = 0; @(negedge clk); end
        rd_valid = 0; @(negedge clk);
        rd_valid = 1; rd_bit = 1; @(negedge clk);
        for (int b = 15; b >= 0; b--) begin
            rd_valid = 1; rd_bit = addr[b];
            if (b > 0) @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        rd_valid = 0; rd_bit = 0;
        gap_n = 0;
        while (!write_gate && gap_n < 200) begin
            @(posedge clk); gap_n++;
            @(negedge clk);
        end
    endtask

    // Full write with a match; checks gap, stream regions, CRC and handshake.
    task automatic good_write(int tgt, int mode, int dly, bit poke_busy);
        int gap_n, bad_ls, bad_clk, bad_data, bad_crc;
        logic [15:0] c;
        data_mode = mode; ack_delay = dly; first_delay = 3;
        clear_obs();
        do_start(tgt, 0);
        repeat (100) @(negedge clk);
        send_preamble({8'(tgt * 37 + 5), 5'(tgt + 9), SW'(tgt)}, tgt + 1, gap_n);
        check(gap_n == 1 + GAP * CELL, "R5 gap length", gap_n, 1 + GAP * CELL);
        if (poke_busy) begin
            do_start(0, 1);
            @(negedge clk);
            check(!err_protect && busy && write_gate, "R12 start while busy", err_protect, 0);
        end
        wait_done(NCELL * CELL + 100);
        c = exp_crc();
        bad_ls = 0; bad_clk = 0; bad_data = 0; bad_crc = 0;
        for (int j = 0; j < cap_n && j < NCELL * CELL; j++) begin
            int cl = j / CELL;
            bit e;
            if (j % CELL < H) begin
                if (lv[j] !== 1'b1) bad_clk++;
            end else if (cl <= LEAD) begin
                e = (cl == LEAD);
                if (lv[j] !== e) bad_ls++;
            end else if (cl < LEAD + 1 + NW * 16) begin
                int d = cl - LEAD - 1;
                e = wval(d / 16)[15 - d % 16];
                if (lv[j] !== e) bad_data++;
            end else begin
                e = c[15 - (cl - LEAD - 1 - NW * 16)];
                if (lv[j] !== e) bad_crc++;
            end
        end
        check(cap_n == NCELL * CELL, "R8 stream length", cap_n, NCELL * CELL);
        check(bad_ls == 0, "R6 leader and sync", bad_ls, 0);
        check(bad_clk == 0, "R7 clock halves", bad_clk, 0);
        check(bad_data == 0, "R8 data bits", bad_data, 0);
        check(bad_crc == 0, "R9 checkword bits", bad_crc, 0);
        check(done_seen && !busy && !write_gate && !err_late && !err_mismatch && !err_protect,
              "R9 clean end", {err_late, err_mismatch, err_protect}, 0);
        check(acks == NW && !word_req, "R10 words requested", acks, NW);
    endtask

    initial begin
        int gap_n;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !write_gate && !word_req && !done && !err_protect && !err_mismatch && !err_late,
              "R13 reset state", busy, 0);

        // R1: write protect refusal.
        clear_obs();
        do_start(2, 1);
        check(err_protect && done_seen && !busy, "R1 protect refused", err_protect, 1);
        repeat (20) @(negedge clk);
        check(!req_seen && !gate_seen, "R1 no request or gate", req_seen, 0);

        // R2/R13: prefetch before the mark, flags cleared by the next start.
        clear_obs();
        do_start(1, 0);
        check(word_req && busy && !err_protect, "R2 prefetch and R13 flag clear", word_req, 1);

        // R3/R4: full sweep of target/sector mismatches, varied other bits.
        begin
            int mm_bad = 0, mm_gate = 0;
            send_preamble({8'hA5, 5'h13, 3'd0}, 2, gap_n);
            wait_done(50);
            check(err_mismatch && !gate_seen, "R4 first mismatch", err_mismatch, 1);
            for (int t = 0; t < 8; t++)
                for (int s = 0; s < 8; s++)
                    if (s != t || t == 7) begin
                        clear_obs();
                        first_delay = 3;
                        do_start(t, 0);
                        send_preamble({8'(s * 29 + t), 5'(t * 3 + s), (s == t) ? 3'(s ^ 1) : 3'(s)},
                                      (s + t) % 4, gap_n);
                        wait_done(50);
                        if (!err_mismatch || !done_seen) mm_bad++;
                        if (gate_seen || word_req) mm_gate++;
                    end
            check(mm_bad == 0, "R4 mismatch sweep flags", mm_bad, 0);
            check(mm_gate == 0, "R3 R4 mismatch sweep no gate", mm_gate, 0);
        end

        // R5..R10: matching writes for every target with varied data and delays.
        for (int t = 0; t < 8; t++)
            good_write(t, t % 3, (t < 4) ? 1 + t * 5 : 2, t == 5);

        // R11: acknowledge exactly on the load edge is accepted (bypass).
        good_write(3, 0, 16 * CELL, 0);

        // R11: one cycle later is data-late.
        clear_obs();
        data_mode = 0; ack_delay = 16 * CELL + 1; first_delay = 3;
        do_start(4, 0);
        repeat (100) @(negedge clk);
        send_preamble({8'h11, 5'h02, 3'd4}, 1, gap_n);
        wait_done(2000);
        check(err_late && done_seen && !write_gate && !busy, "R11 late mid-sector", err_late, 1);
        check(cap_n == (LEAD + 1 + 16) * CELL, "R11 gate dropped at load edge", cap_n, (LEAD + 1 + 16) * CELL);
        check(!word_req, "R10 request dropped after abort", word_req, 0);

        // R11: first word never arrives before the sync ends.
        clear_obs();
        ack_delay = 1; first_delay = 100000;
        do_start(6, 0);
        repeat (10) @(negedge clk);
        send_preamble({8'h40, 5'h07, 3'd6}, 0, gap_n);
        wait_done(500);
        check(err_late && !write_gate && cap_n == (LEAD + 1) * CELL, "R11 late at sync", cap_n, (LEAD + 1) * CELL);
        first_delay = 3;

        // R13: late flag clears on next accepted start.
        do_start(0, 1);
        check(!err_late && err_protect, "R13 flags clear on start", err_late, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule